// File: doc/BRIEF.md
# Breathing LED PWM Engine

This block drives a single LED pin with a pulse-width-modulated waveform. In breathe mode the duty cycle climbs and falls on its own, and the LED appears to breathe. The ramp is divided into eight segments. Each segment has its own step size and its own pacing, so the brightness curve can follow any shape a designer chooses. At the top and bottom of the ramp the duty stays fixed for a programmable number of PWM periods. The block also has a forced-off mode and a forced-on mode. A fourth mode code belongs to a blink engine that lives elsewhere, and this block keeps its pin low in that mode.

The configuration arrives as register-style inputs. While the engine is breathing, it keeps working copies of the segment tables, the thresholds and the delays. Changes on the inputs reach those copies only after an update strobe, and only at the end of a PWM period. The busy flag shows that an update is still pending. The PWM resolution is not buffered: a change to it takes effect at once.

Top module: `breath_led_engine`

## Requirements
- R1: The mode input uses these codes: 0 (off) and 2 (blink, handled elsewhere) drive `ledOut` low, 3 (on) drives it high, and 1 is breathe.
- R2: In breathe mode the width code selects the PWM resolution: 0 is 8 bits, 1 is 7 bits, and 2 or 3 is 6 bits. A PWM period lasts 2^w clocks, counted from 0 to 2^w-1. `ledOut` is high while the count is below the current duty, which is min(duty, 2^w) clocks per period.
- R3: When the block enters breathe mode, the duty starts at 0 and the engine is in the low hold. Leaving breathe mode clears the duty, so the first period after re-entry shows no high clocks.
- R4: Segment i takes its step from bits 4i+3:4i of the step word and its interval from the same bits of the interval word. In symmetric operation the segment is the top three bits of the duty (duty >> (w-3)). During a ramp the duty moves by the segment's step once every interval+1 period ends.
- R5: A step up saturates at full scale (2^w-1), and a step down saturates at 0. Before the step, and before the segment is chosen, a duty above full scale is treated as full scale.
- R6: A rising step whose result is at or above the upper threshold, or equal to full scale, starts the high hold. A falling step whose result is at or below the lower threshold, or equal to 0, starts the low hold. A hold ends at the period end at which its period count has reached the high or low delay, which is delay+1 period ends after the hold began. The opposite ramp then starts its interval count from zero.
- R7: With the asymmetric enable set, the segment index is {falling, duty >> (w-2)}. A rising ramp therefore uses segments 0-3 and a falling ramp uses segments 4-7.
- R8: In breathe mode, changes to the step word, interval word, thresholds and delays do not affect the ramp until an update strobe. The new values are copied at the first period end after the strobe, and the period that ends there still uses the old values.
- R9: In breathe mode an update strobe raises `updBusy` on the next clock. `updBusy` stays high until the period end that copies the values, and it is low from the following clock.
- R10: Outside breathe mode the working copies follow the inputs on every clock without a strobe, and `updBusy` is low.
- R11: A change of the width code takes effect without an update strobe.
- R12: While reset is asserted, `ledOut` and `updBusy` are low even with breathe mode selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Mode code (off, breathe, blink, on) |
| widthSel | input | 2 | PWM resolution code |
| asymEn | input | 1 | Separate rising and falling segment sets |
| stepWord | input | 32 | Eight 4-bit step fields |
| intvWord | input | 32 | Eight 4-bit interval fields |
| minHold | input | 8 | Lower hold threshold |
| maxHold | input | 8 | Upper hold threshold |
| lowDelay | input | 16 | Periods spent in the low hold |
| highDelay | input | 16 | Periods spent in the high hold |
| updStrobe | input | 1 | Request to copy new parameters |
| ledOut | output | 1 | LED drive |
| updBusy | output | 1 | Parameter update pending |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and 16-bit delays. It drives the width code to every resolution. With the 6-bit and 7-bit resolutions a period is only 64 or 128 clocks, so full ramps, both holds, saturation and asymmetric segment sets all fit within a few thousand clocks. The 8-bit case is still run for a full rise and fall. The delays are kept small so that each hold-length rule is reached many times. Each period's high-clock count is compared against a period-level model.

// File: rtl/bled_pkg.sv
package bled_pkg;
  localparam int SEG_COUNT = 8;
  localparam int SEG_BITS  = $clog2(SEG_COUNT);
  localparam int FIELD_W   = 4;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_BREATHE = 2'd1,
    MODE_BLINK   = 2'd2,
    MODE_ON      = 2'd3
  } ledMode_e;

  typedef enum logic [1:0] {
    PH_HOLD_LO,
    PH_RISE,
    PH_HOLD_HI,
    PH_FALL
  } rampPhase_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic pwmEn;      // breathe waveform drives the pin
    logic forceOn;    // pin held high
    logic clearDuty;  // return duty to zero
    logic loadParams; // copy inputs into working registers
    logic stepUp;     // apply rising step
    logic stepDown;   // apply falling step
    logic dirDown;    // ramp is falling (segment selection)
  } bledCmd_t;
endpackage

// File: rtl/bled_ctrl.sv
module bled_ctrl
  import bled_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [1:0]         widthSel,
  input  logic               updStrobe,
  input  logic [FIELD_W-1:0] segIntv,
  input  logic               upHitsTop,
  input  logic               downHitsBottom,
  input  logic [DLY_W-1:0]   lowDelay,
  input  logic [DLY_W-1:0]   highDelay,
  output logic [CNT_W-1:0]   pwmCnt,
  output logic [CNT_W-1:0]   fullScale,
  output logic [1:0]         shrink,
  output bledCmd_t           cmd,
  output logic               updBusy
);
  logic             isBreathe;
  logic             periodEnd;
  logic             intvHit;
  logic             pendQ;
  rampPhase_e       phaseQ;
  logic [DLY_W-1:0] dlyCnt;
  logic [FIELD_W-1:0] intvCnt;

  assign isBreathe = (modeSel == MODE_BREATHE);
  assign shrink    = (widthSel == 2'd3) ? 2'd2 : widthSel;
  assign fullScale = {CNT_W{1'b1}} >> shrink;
  // A shrinking width can leave the counter above full scale; end the period then too
  assign periodEnd = isBreathe && (pwmCnt >= fullScale);
  assign intvHit   = (intvCnt == segIntv);
  assign updBusy   = pendQ;

  always_comb begin
    cmd            = '0;
    cmd.pwmEn      = isBreathe;
    cmd.forceOn    = (modeSel == MODE_ON);
    cmd.clearDuty  = !isBreathe;
    cmd.loadParams = !isBreathe || (periodEnd && pendQ);
    cmd.stepUp     = periodEnd && (phaseQ == PH_RISE) && intvHit;
    cmd.stepDown   = periodEnd && (phaseQ == PH_FALL) && intvHit;
    cmd.dirDown    = (phaseQ == PH_FALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt  <= '0;
      pendQ   <= 1'b0;
      phaseQ  <= PH_HOLD_LO;
      dlyCnt  <= '0;
      intvCnt <= '0;
    end else if (!isBreathe) begin
      pwmCnt  <= '0;
      pendQ   <= 1'b0;
      phaseQ  <= PH_HOLD_LO;
      dlyCnt  <= '0;
      intvCnt <= '0;
    end else begin
      pwmCnt <= periodEnd ? '0 : pwmCnt + 1'b1;
      if (updStrobe)      pendQ <= 1'b1;
      else if (periodEnd) pendQ <= 1'b0;
      if (periodEnd) begin
        unique case (phaseQ)
          PH_HOLD_LO: begin
            if (dlyCnt >= lowDelay) begin
              phaseQ  <= PH_RISE;
              dlyCnt  <= '0;
              intvCnt <= '0;
            end else begin
              dlyCnt <= dlyCnt + 1'b1;
            end
          end
          PH_HOLD_HI: begin
            if (dlyCnt >= highDelay) begin
              phaseQ  <= PH_FALL;
              dlyCnt  <= '0;
              intvCnt <= '0;
            end else begin
              dlyCnt <= dlyCnt + 1'b1;
            end
          end
          PH_RISE: begin
            if (intvHit) begin
              intvCnt <= '0;
              if (upHitsTop) begin
                phaseQ <= PH_HOLD_HI;
                dlyCnt <= '0;
              end
            end else begin
              intvCnt <= intvCnt + 1'b1;
            end
          end
          PH_FALL: begin
            if (intvHit) begin
              intvCnt <= '0;
              if (downHitsBottom) begin
                phaseQ <= PH_HOLD_LO;
                dlyCnt <= '0;
              end
            end else begin
              intvCnt <= intvCnt + 1'b1;
            end
          end
          default: phaseQ <= PH_HOLD_LO;
        endcase
      end
    end
  end
endmodule

// File: rtl/bled_datapath.sv
module bled_datapath
  import bled_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bledCmd_t                     cmd,
  input  logic [CNT_W-1:0]             pwmCnt,
  input  logic [CNT_W-1:0]             fullScale,
  input  logic [1:0]                   shrink,
  input  logic                         asymEn,
  input  logic [SEG_COUNT*FIELD_W-1:0] stepWord,
  input  logic [SEG_COUNT*FIELD_W-1:0] intvWord,
  input  logic [CNT_W-1:0]             minHold,
  input  logic [CNT_W-1:0]             maxHold,
  input  logic [DLY_W-1:0]             lowDelayIn,
  input  logic [DLY_W-1:0]             highDelayIn,
  output logic [FIELD_W-1:0]           segIntv,
  output logic                         upHitsTop,
  output logic                         downHitsBottom,
  output logic [DLY_W-1:0]             lowDelay,
  output logic [DLY_W-1:0]             highDelay,
  output logic                         ledOut
);
  localparam int TABLE_W = SEG_COUNT * FIELD_W;

  logic [TABLE_W-1:0] wStep, wIntv;
  logic [CNT_W-1:0]   wMin, wMax;
  logic [CNT_W-1:0]   dutyQ;
  logic [CNT_W-1:0]   clampDuty;
  logic [FIELD_W-1:0] stepArr [SEG_COUNT];
  logic [FIELD_W-1:0] intvArr [SEG_COUNT];
  logic [SEG_BITS-1:0] symSeg, asymSeg, segIdx;
  logic [FIELD_W-1:0] curStep;
  logic [CNT_W:0]     upSum;
  logic [CNT_W-1:0]   upVal, downVal;
  int                 segShift;

  // Working copies of the buffered parameters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wStep     <= '0;
      wIntv     <= '0;
      wMin      <= '0;
      wMax      <= '0;
      lowDelay  <= '0;
      highDelay <= '0;
    end else if (cmd.loadParams) begin
      wStep     <= stepWord;
      wIntv     <= intvWord;
      wMin      <= minHold;
      wMax      <= maxHold;
      lowDelay  <= lowDelayIn;
      highDelay <= highDelayIn;
    end
  end

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_fields
    assign stepArr[g] = wStep[g*FIELD_W +: FIELD_W];
    assign intvArr[g] = wIntv[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    clampDuty = (dutyQ > fullScale) ? fullScale : dutyQ;
    segShift  = CNT_W - SEG_BITS - int'(shrink);
    symSeg    = SEG_BITS'(clampDuty >> segShift);
    asymSeg   = {cmd.dirDown, (SEG_BITS-1)'(clampDuty >> (segShift + 1))};
    segIdx    = asymEn ? asymSeg : symSeg;
    curStep   = stepArr[segIdx];
    segIntv   = intvArr[segIdx];

    upSum   = {1'b0, clampDuty} + (CNT_W+1)'(curStep);
    upVal   = (upSum > {1'b0, fullScale}) ? fullScale : upSum[CNT_W-1:0];
    downVal = (clampDuty > CNT_W'(curStep)) ? (clampDuty - CNT_W'(curStep)) : '0;

    upHitsTop      = (upVal >= wMax) || (upVal == fullScale);
    downHitsBottom = (downVal <= wMin) || (downVal == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dutyQ <= '0;
    else if (cmd.clearDuty) dutyQ <= '0;
    else if (cmd.stepUp)    dutyQ <= upVal;
    else if (cmd.stepDown)  dutyQ <= downVal;
  end

  assign ledOut = cmd.forceOn || (cmd.pwmEn && (pwmCnt < dutyQ));
endmodule

// File: rtl/breath_led_engine.sv
module breath_led_engine
  import bled_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   modeSel,
  input  logic [1:0]                   widthSel,
  input  logic                         asymEn,
  input  logic [SEG_COUNT*FIELD_W-1:0] stepWord,
  input  logic [SEG_COUNT*FIELD_W-1:0] intvWord,
  input  logic [CNT_W-1:0]             minHold,
  input  logic [CNT_W-1:0]             maxHold,
  input  logic [DLY_W-1:0]             lowDelay,
  input  logic [DLY_W-1:0]             highDelay,
  input  logic                         updStrobe,
  output logic                         ledOut,
  output logic                         updBusy
);
  bledCmd_t           cmdBus;
  logic [CNT_W-1:0]   pwmCnt;
  logic [CNT_W-1:0]   fullScale;
  logic [1:0]         shrink;
  logic [FIELD_W-1:0] segIntv;
  logic               upHitsTop;
  logic               downHitsBottom;
  logic [DLY_W-1:0]   workLow;
  logic [DLY_W-1:0]   workHigh;

  bled_ctrl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .modeSel        (modeSel),
    .widthSel       (widthSel),
    .updStrobe      (updStrobe),
    .segIntv        (segIntv),
    .upHitsTop      (upHitsTop),
    .downHitsBottom (downHitsBottom),
    .lowDelay       (workLow),
    .highDelay      (workHigh),
    .pwmCnt         (pwmCnt),
    .fullScale      (fullScale),
    .shrink         (shrink),
    .cmd            (cmdBus),
    .updBusy        (updBusy)
  );

  bled_datapath #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (cmdBus),
    .pwmCnt         (pwmCnt),
    .fullScale      (fullScale),
    .shrink         (shrink),
    .asymEn         (asymEn),
    .stepWord       (stepWord),
    .intvWord       (intvWord),
    .minHold        (minHold),
    .maxHold        (maxHold),
    .lowDelayIn     (lowDelay),
    .highDelayIn    (highDelay),
    .segIntv        (segIntv),
    .upHitsTop      (upHitsTop),
    .downHitsBottom (downHitsBottom),
    .lowDelay       (workLow),
    .highDelay      (workHigh),
    .ledOut         (ledOut)
  );
endmodule

// File: rtl/breath_led_engine_chk.sv
module breath_led_engine_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             updStrobe,
  input logic             ledOut,
  input logic             updBusy,
  input logic [CNT_W-1:0] pwmCnt
);
  assert_off_dark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0) |-> !ledOut);

  assert_on_lit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd3) |-> ledOut);

  assert_entry_dark_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 && $past(modeSel) != 2'd1) |-> !ledOut);

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 && updStrobe) |=> updBusy);

  assert_busy_drop_at_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(updBusy) && $past(modeSel) == 2'd1) |-> (pwmCnt == '0));

  assert_idle_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'd1) |=> !updBusy);
endmodule

bind breath_led_engine breath_led_engine_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .updStrobe (updStrobe),
  .ledOut    (ledOut),
  .updBusy   (updBusy),
  .pwmCnt    (pwmCnt)
);

// File: tb/breath_led_engine_tb_top.sv
module breath_led_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [1:0]  widthSel = 2'd2;
  logic        asymEn = 1'b0;
  logic [31:0] stepWord = '0;
  logic [31:0] intvWord = '0;
  logic [7:0]  minHold = '0;
  logic [7:0]  maxHold = '0;
  logic [15:0] lowDelay = '0;
  logic [15:0] highDelay = '0;
  logic        updStrobe = 1'b0;
  logic        ledOut;
  logic        updBusy;

  always #2 clk = ~clk;

  breath_led_engine dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .widthSel(widthSel),
    .asymEn(asymEn), .stepWord(stepWord), .intvWord(intvWord),
    .minHold(minHold), .maxHold(maxHold), .lowDelay(lowDelay),
    .highDelay(highDelay), .updStrobe(updStrobe), .ledOut(ledOut),
    .updBusy(updBusy)
  );

  int checks = 0;
  int fails = 0;

  // Period-level reference state
  int mDuty, mPhase, mDly, mIntv, mW;
  logic [31:0] wS, wI;
  int wMin, wMax, wLo, wHi;

  typedef struct packed {
    logic [1:0]  wsel;
    logic [31:0] steps;
    logic [31:0] intvs;
    logic [7:0]  minH;
    logic [7:0]  maxH;
    logic [15:0] lowD;
    logic [15:0] highD;
    logic        asym;
    logic [7:0]  nPer;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 32'h87654321, 32'h00000000, 8'd0,  8'd40,  16'd1, 16'd2, 1'b0, 8'd40},
    '{2'd2, 32'hFFFFFFFF, 32'h00000000, 8'd0,  8'd255, 16'd0, 16'd0, 1'b0, 8'd20},
    '{2'd2, 32'h11114444, 32'h00001010, 8'd8,  8'd32,  16'd2, 16'd0, 1'b1, 8'd50},
    '{2'd1, 32'hFEDCBA98, 32'h01230123, 8'd10, 8'd100, 16'd0, 16'd1, 1'b0, 8'd30},
    '{2'd0, 32'hFFFFFFFF, 32'h00000000, 8'd20, 8'd200, 16'd0, 16'd0, 1'b0, 8'd30}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nib(input logic [31:0] w, input int i);
    return int'((w >> (4 * i)) & 32'hF);
  endfunction

  task automatic modelReset();
    mDuty = 0; mPhase = 0; mDly = 0; mIntv = 0;
  endtask

  task automatic modelLoad();
    wS = stepWord; wI = intvWord;
    wMin = int'(minHold); wMax = int'(maxHold);
    wLo = int'(lowDelay); wHi = int'(highDelay);
  endtask

  // One period end, from the requirements
  task automatic modelEnd(input int asym);
    int full, dc, seg, st, iv, nd;
    full = (1 << mW) - 1;
    dc = (mDuty > full) ? full : mDuty;
    if (asym != 0) seg = ((mPhase == 3) ? 4 : 0) + (dc >> (mW - 2));
    else           seg = dc >> (mW - 3);
    st = nib(wS, seg);
    iv = nib(wI, seg);
    case (mPhase)
      0: if (mDly >= wLo) begin mPhase = 1; mDly = 0; mIntv = 0; end else mDly++;
      2: if (mDly >= wHi) begin mPhase = 3; mDly = 0; mIntv = 0; end else mDly++;
      1: if (mIntv == iv) begin
           mIntv = 0;
           nd = dc + st;
           if (nd > full) nd = full;
           mDuty = nd;
           if (nd >= wMax || nd == full) begin mPhase = 2; mDly = 0; end
         end else mIntv++;
      default: if (mIntv == iv) begin
           mIntv = 0;
           nd = (dc > st) ? dc - st : 0;
           mDuty = nd;
           if (nd <= wMin || nd == 0) begin mPhase = 0; mDly = 0; end
         end else mIntv++;
    endcase
  endtask

  // Starts at a negedge aligned to a period start; returns at the next one
  task automatic measure(input int P, input int asym, input string req, input bit pulse);
    int hi = 0;
    int expv;
    for (int i = 0; i < P; i++) begin
      #1;
      if (ledOut) hi++;
      if (pulse && i == 10) updStrobe = 1'b1;
      if (pulse && i == 11) updStrobe = 1'b0;
      if (pulse && i == 20) check(updBusy == 1'b1, "R9 busy after strobe", int'(updBusy), 1);
      @(negedge clk);
    end
    expv = (mDuty < P) ? mDuty : P;
    check(hi == expv, req, hi, expv);
    modelEnd(asym);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R12: reset holds the outputs low even with breathe selected
    modeSel = 2'd1;
    repeat (3) @(negedge clk);
    check(ledOut == 1'b0, "R12 led in reset", int'(ledOut), 0);
    check(updBusy == 1'b0, "R12 busy in reset", int'(updBusy), 0);
    modeSel = 2'd0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: fixed modes
    modeSel = 2'd3; #1;
    check(ledOut == 1'b1, "R1 on mode", int'(ledOut), 1);
    @(negedge clk);
    modeSel = 2'd2; #1;
    check(ledOut == 1'b0, "R1 blink code", int'(ledOut), 0);
    @(negedge clk);
    modeSel = 2'd0; #1;
    check(ledOut == 1'b0, "R1 off mode", int'(ledOut), 0);
    // R10: a strobe outside breathe leaves busy low
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
    @(negedge clk);
    check(updBusy == 1'b0, "R10 busy outside breathe", int'(updBusy), 0);

    // Vector table: parameters loaded while off (R10), then the ramp is followed
    foreach (VECS[v]) begin
      modeSel   = 2'd0;
      widthSel  = VECS[v].wsel;
      stepWord  = VECS[v].steps;
      intvWord  = VECS[v].intvs;
      minHold   = VECS[v].minH;
      maxHold   = VECS[v].maxH;
      lowDelay  = VECS[v].lowD;
      highDelay = VECS[v].highD;
      asymEn    = VECS[v].asym;
      repeat (2) @(negedge clk);
      modelLoad();
      mW = 8 - ((VECS[v].wsel == 2'd3) ? 2 : int'(VECS[v].wsel));
      modelReset();
      modeSel = 2'd1;
      for (int p = 0; p < int'(VECS[v].nPer); p++)
        measure(1 << mW, int'(VECS[v].asym),
                VECS[v].asym ? "R7 R2 R4 R6 R10" : "R2 R4 R5 R6 R10", 1'b0);
    end

    // Buffered update (R8, R9)
    modeSel = 2'd0; widthSel = 2'd2; asymEn = 1'b0;
    stepWord = 32'h22222222; intvWord = '0;
    minHold = 8'd0; maxHold = 8'd63; lowDelay = 16'd0; highDelay = 16'd0;
    repeat (2) @(negedge clk);
    modelLoad(); mW = 6; modelReset();
    modeSel = 2'd1;
    for (int p = 0; p < 3; p++) measure(64, 0, "R3 R4", 1'b0);
    stepWord = 32'h55555555;
    for (int p = 0; p < 2; p++) measure(64, 0, "R8 unstrobed change ignored", 1'b0);
    measure(64, 0, "R8 old values until period end", 1'b1);
    modelLoad();
    check(updBusy == 1'b0, "R9 busy cleared after copy", int'(updBusy), 0);
    for (int p = 0; p < 3; p++) measure(64, 0, "R8 new values applied", 1'b0);

    // R11: width change at a period boundary, no strobe
    widthSel = 2'd1; mW = 7;
    for (int p = 0; p < 4; p++) measure(128, 0, "R11 width switch", 1'b0);

    // R3: leaving breathe clears the duty
    modeSel = 2'd0; #1;
    check(ledOut == 1'b0, "R1 off after breathe", int'(ledOut), 0);
    @(negedge clk);
    modeSel = 2'd1;
    modelReset();
    measure(128, 0, "R3 re-entry starts dark", 1'b0);
    measure(128, 0, "R3 re-entry low hold", 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule